// File: doc/BRIEF.md
# Multi-Depth Pixel Unpacker

This block sits between a framebuffer fetch engine and a color pipeline. It takes 32-bit framebuffer words over a valid/ready handshake and splits each word into pixels at one of eight depths. Each pixel leaves on a second valid/ready handshake, one per cycle. The four narrow depths produce an 8-bit palette index for a lookup stage further down. The four wide depths produce a 24-bit direct color with the channels widened to 8 bits each.

The pixel-mode code, the BGR flag, the two ordering flags and the 2-bit external format select are sampled together with each input word, so a change of format takes effect on a word boundary. A line-start strobe drops whatever is left of the word being unpacked, so each display line begins on a fresh word. Alongside the datapath, a separate combinational output reports how many framebuffer bytes a line of a given pixel width occupies at the current mode.

When the parameter `EXT_SEL_EN` is 0, the 16-bit mode always decodes as 5551, and the 565 layout is only reachable through mode code 6.

Top module: `pix_unpack`

## Requirements
- R1: The mode code selects bits per pixel as 0→1, 1→2, 2→4, 3→8, 4→16, 5→32, 6→16 (565), 7→12 (stored in a 16-bit slot, bits 11:0). Each accepted word yields exactly 32/bpp output pixels. The mode, flags and format select are taken from the cycle in which the word is accepted.
- R2: Modes 0–3 drive `out_is_color_o`=0, put the pixel value zero-extended on `out_index_o` and drive `out_color_o` to 0. Modes 4–7 drive `out_is_color_o`=1 and `out_index_o`=0.
- R3: With both ordering flags clear, pixel k of a word comes from bits [k*bpp +: bpp], so the least significant end is used first.
- R4: With `be_byte_i` set, pixel k comes from bits [32-(k+1)*bpp +: bpp], so the most significant end is used first. This holds whatever the value of `be_pix_i`.
- R5: With only `be_pix_i` set, bytes are used from the least significant byte upward. Within a byte, sub-byte pixels are taken from the most significant bits first. The flag has no effect at 8 bpp and above.
- R6: Direct color is `{R,G,B}` in bits 23:16, 15:8 and 7:0. The field layouts, from bit 0 upward, are: 5551 = R[4:0], G[9:5], B[14:10], with bit 15 ignored; 565 = R[4:0], G[10:5], B[15:11]; 12-bit = R[3:0], G[7:4], B[11:8]; 32 bpp = R[7:0], G[15:8], B[23:16], with bits 31:24 ignored. Each channel is left-aligned and zero-filled.
- R7: `bgr_i`=1 swaps the R and B output channels in every direct-color format.
- R8: In mode 4 with `EXT_SEL_EN`=1, `fmt_sel_i`=1 decodes 5551, `fmt_sel_i`=3 decodes 565 with the R/B swap forced on, and `fmt_sel_i`=0 or 2 decodes 565 following `bgr_i`.
- R9: While pixels of the held word remain, `in_ready_o` is low unless the last pixel is taken in that cycle. In that cycle a new word can be accepted, so there is no bubble.
- R10: While `out_valid_o` is high and `out_ready_i` is low, the output pixel stays valid and unchanged in the next cycle, unless a line start intervenes.
- R11: In a cycle with `line_start_i` high, `in_ready_o` and `out_valid_o` are low and the held word is discarded. The next accepted word starts at its pixel 0.
- R12: `line_bytes_o` equals the following, by mode: `line_width_i`/8 for mode 0, /4 for mode 1, /2 for mode 2, ×1 for mode 3, ×2 for modes 4, 6 and 7, and ×4 for mode 5.
- R13: During and right after reset, `out_valid_o`=0 and `in_ready_o`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Pixel-mode code, sampled with the word |
| bgr_i | input | 1 | Swap R and B channels |
| be_byte_i | input | 1 | Take pixels from the most significant end of the word first |
| be_pix_i | input | 1 | Take sub-byte pixels from the high bits of each byte first |
| fmt_sel_i | input | 2 | External format select for mode 4 |
| line_start_i | input | 1 | Discard the held word; next word starts a line |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Input word accepted when high with valid |
| in_data_i | input | 32 | Framebuffer word |
| out_valid_o | output | 1 | Output pixel valid |
| out_ready_i | input | 1 | Downstream takes the pixel |
| out_is_color_o | output | 1 | 1: direct color, 0: palette index |
| out_index_o | output | 8 | Palette index |
| out_color_o | output | 24 | Direct color {R,G,B} |
| line_width_i | input | WIDTH_W | Line width in pixels |
| line_bytes_o | output | WIDTH_W+2 | Bytes per line at mode_i |

## Verification
The bench runs every mode under all four combinations of the ordering flags and both BGR settings, while downstream ready is throttled pseudo-randomly. A slicing error therefore shows up as pixels arriving in the wrong order, or with bits mixed between neighbouring pixels. It also catches a byte-order flag that fails to override the pixel-order flag, which would reverse sub-byte pixels inside each byte. The four format-select values in mode 4 are each paired with both BGR settings, so a design that ignores the forced swap, or keeps 5551 for select 0 or 2, produces wrong channel values. A line start is issued while a 1 bpp word is still mostly unread; a design that keeps the stale word would emit its leftover pixels ahead of the new word. Back-to-back 32 bpp words expose an extra idle cycle between words, and held-output checks catch a pixel that moves while stalled.

// File: rtl/pu_pkg.sv
package pu_pkg;
   localparam int WORD_W = 32;
   localparam int SLOT_W = $clog2(WORD_W);

   typedef enum logic [2:0] {
      PM_1 = 3'd0, PM_2 = 3'd1, PM_4 = 3'd2, PM_8 = 3'd3,
      PM_16 = 3'd4, PM_32 = 3'd5, PM_565 = 3'd6, PM_12 = 3'd7
   } pix_mode_e;

   typedef enum logic [1:0] {
      DF_5551, DF_565, DF_444, DF_888
   } dfmt_e;

   typedef struct packed {
      logic [2:0] mode;
      logic       bgr;
      logic       be_byte;
      logic       be_pix;
      logic [1:0] sel;
   } pu_cfg_t;

   // log2 of the container width in bits for each mode code
   function automatic logic [2:0] depth_log2(input logic [2:0] m);
      case (m)
         PM_1:    depth_log2 = 3'd0;
         PM_2:    depth_log2 = 3'd1;
         PM_4:    depth_log2 = 3'd2;
         PM_8:    depth_log2 = 3'd3;
         PM_32:   depth_log2 = 3'd5;
         default: depth_log2 = 3'd4;
      endcase
   endfunction
endpackage

// File: rtl/pu_slot_ctrl.sv
module pu_slot_ctrl
   import pu_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                line_start_i,
   input  logic                in_valid_i,
   input  logic [WORD_W-1:0]   in_data_i,
   input  pu_cfg_t             in_cfg_i,
   output logic                in_ready_o,
   input  logic                out_ready_i,
   output logic                out_valid_o,
   output logic [WORD_W-1:0]   word_o,
   output pu_cfg_t             cfg_o,
   output logic [SLOT_W-1:0]   slot_o
);
   logic              full_q;
   logic [SLOT_W-1:0] slot_q;
   logic [WORD_W-1:0] word_q;
   pu_cfg_t           cfg_q;
   logic [SLOT_W-1:0] last_slot;
   logic              at_last, take_out, take_in;

   always_comb begin
      last_slot  = SLOT_W'((WORD_W >> depth_log2(cfg_q.mode)) - 1);
      at_last    = (slot_q == last_slot);
      take_out   = full_q && out_ready_i && !line_start_i;
      in_ready_o = !line_start_i && (!full_q || (out_ready_i && at_last));
      take_in    = in_valid_i && in_ready_o;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         slot_q <= '0;
         word_q <= '0;
         cfg_q  <= '0;
      end else if (line_start_i) begin
         full_q <= 1'b0;
         slot_q <= '0;
      end else if (take_in) begin
         full_q <= 1'b1;
         slot_q <= '0;
         word_q <= in_data_i;
         cfg_q  <= in_cfg_i;
      end else if (take_out) begin
         if (at_last) begin
            full_q <= 1'b0;
            slot_q <= '0;
         end else begin
            slot_q <= slot_q + 1'b1;
         end
      end
   end

   assign out_valid_o = full_q && !line_start_i;
   assign word_o      = word_q;
   assign cfg_o       = cfg_q;
   assign slot_o      = slot_q;
endmodule

// File: rtl/pu_extract.sv
module pu_extract
   import pu_pkg::*;
(
   input  logic [WORD_W-1:0] word_i,
   input  pu_cfg_t           cfg_i,
   input  logic [SLOT_W-1:0] slot_i,
   output logic [WORD_W-1:0] field_o
);
   logic [2:0] lg;
   logic [5:0] bpp, lsb_off, off;

   always_comb begin
      lg      = depth_log2(cfg_i.mode);
      bpp     = 6'd1 << lg;
      lsb_off = {1'b0, slot_i} << lg;
      if (cfg_i.be_byte)
         off = 6'd32 - bpp - lsb_off;
      else if (cfg_i.be_pix && lg < 3'd3)
         off = {lsb_off[5:3], 3'b000} + 6'd8 - bpp - {3'b000, lsb_off[2:0]};
      else
         off = lsb_off;
      field_o = word_i >> off;
   end
endmodule

// File: rtl/pu_color.sv
module pu_color
   import pu_pkg::*;
#(
   parameter int EXT_SEL_EN = 1
) (
   input  logic [WORD_W-1:0] field_i,
   input  pu_cfg_t           cfg_i,
   output logic              is_color_o,
   output logic [7:0]        index_o,
   output logic [23:0]       color_o
);
   logic       m16_is_565;
   logic       m16_force_swap;
   dfmt_e      fmt;
   logic       swap;
   logic [2:0] lg;
   logic [7:0] c0, c1, c2, idx;

   generate
      if (EXT_SEL_EN != 0) begin : g_ext_sel
         always_comb begin
            m16_is_565     = (cfg_i.sel != 2'd1);
            m16_force_swap = (cfg_i.sel == 2'd3);
         end
      end else begin : g_native
         always_comb begin
            m16_is_565     = 1'b0;
            m16_force_swap = 1'b0;
         end
      end
   endgenerate

   always_comb begin
      lg   = depth_log2(cfg_i.mode);
      swap = cfg_i.bgr;
      case (cfg_i.mode)
         PM_32:  fmt = DF_888;
         PM_565: fmt = DF_565;
         PM_12:  fmt = DF_444;
         PM_16: begin
            fmt  = m16_is_565 ? DF_565 : DF_5551;
            swap = cfg_i.bgr | m16_force_swap;
         end
         default: fmt = DF_5551;
      endcase

      case (fmt)
         DF_565: begin
            c0 = {field_i[4:0],   3'b000};
            c1 = {field_i[10:5],  2'b00};
            c2 = {field_i[15:11], 3'b000};
         end
         DF_444: begin
            c0 = {field_i[3:0],  4'h0};
            c1 = {field_i[7:4],  4'h0};
            c2 = {field_i[11:8], 4'h0};
         end
         DF_888: begin
            c0 = field_i[7:0];
            c1 = field_i[15:8];
            c2 = field_i[23:16];
         end
         default: begin
            c0 = {field_i[4:0],   3'b000};
            c1 = {field_i[9:5],   3'b000};
            c2 = {field_i[14:10], 3'b000};
         end
      endcase

      case (lg)
         3'd0:    idx = {7'b0, field_i[0]};
         3'd1:    idx = {6'b0, field_i[1:0]};
         3'd2:    idx = {4'b0, field_i[3:0]};
         default: idx = field_i[7:0];
      endcase

      is_color_o = cfg_i.mode[2];
      index_o    = is_color_o ? 8'd0 : idx;
      if (!is_color_o)
         color_o = 24'd0;
      else if (swap)
         color_o = {c2, c1, c0};
      else
         color_o = {c0, c1, c2};
   end
endmodule

// File: rtl/pu_linebytes.sv
module pu_linebytes
   import pu_pkg::*;
#(
   parameter int WIDTH_W = 12
) (
   input  logic [2:0]         mode_i,
   input  logic [WIDTH_W-1:0] width_i,
   output logic [WIDTH_W+1:0] bytes_o
);
   logic [WIDTH_W+1:0] w_ext;

   always_comb begin
      w_ext = {2'b00, width_i};
      case (mode_i)
         PM_1:    bytes_o = w_ext >> 3;
         PM_2:    bytes_o = w_ext >> 2;
         PM_4:    bytes_o = w_ext >> 1;
         PM_8:    bytes_o = w_ext;
         PM_32:   bytes_o = w_ext << 2;
         default: bytes_o = w_ext << 1;
      endcase
   end
endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
   import pu_pkg::*;
#(
   parameter int WIDTH_W    = 12,
   parameter int EXT_SEL_EN = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2:0]         mode_i,
   input  logic               bgr_i,
   input  logic               be_byte_i,
   input  logic               be_pix_i,
   input  logic [1:0]         fmt_sel_i,
   input  logic               line_start_i,
   input  logic               in_valid_i,
   output logic               in_ready_o,
   input  logic [31:0]        in_data_i,
   output logic               out_valid_o,
   input  logic               out_ready_i,
   output logic               out_is_color_o,
   output logic [7:0]         out_index_o,
   output logic [23:0]        out_color_o,
   input  logic [WIDTH_W-1:0] line_width_i,
   output logic [WIDTH_W+1:0] line_bytes_o
);
   generate
      if (WIDTH_W < 3 || WIDTH_W > 16) begin : g_bad_width
         $error("pix_unpack: WIDTH_W must lie in 3..16");
      end
      if (EXT_SEL_EN != 0 && EXT_SEL_EN != 1) begin : g_bad_sel
         $error("pix_unpack: EXT_SEL_EN must be 0 or 1");
      end
   endgenerate

   pu_cfg_t           cfg_in, cfg_held;
   logic [WORD_W-1:0] word_held, field;
   logic [SLOT_W-1:0] slot;

   assign cfg_in = '{mode: mode_i, bgr: bgr_i, be_byte: be_byte_i,
                     be_pix: be_pix_i, sel: fmt_sel_i};

   pu_slot_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .line_start_i (line_start_i),
      .in_valid_i   (in_valid_i),
      .in_data_i    (in_data_i),
      .in_cfg_i     (cfg_in),
      .in_ready_o   (in_ready_o),
      .out_ready_i  (out_ready_i),
      .out_valid_o  (out_valid_o),
      .word_o       (word_held),
      .cfg_o        (cfg_held),
      .slot_o       (slot)
   );

   pu_extract u_extract (
      .word_i  (word_held),
      .cfg_i   (cfg_held),
      .slot_i  (slot),
      .field_o (field)
   );

   pu_color #(.EXT_SEL_EN(EXT_SEL_EN)) u_color (
      .field_i    (field),
      .cfg_i      (cfg_held),
      .is_color_o (out_is_color_o),
      .index_o    (out_index_o),
      .color_o    (out_color_o)
   );

   pu_linebytes #(.WIDTH_W(WIDTH_W)) u_lbytes (
      .mode_i  (mode_i),
      .width_i (line_width_i),
      .bytes_o (line_bytes_o)
   );
endmodule

// File: rtl/pu_checker.sv
module pu_checker (
   input logic        clk,
   input logic        rst_n,
   input logic [2:0]  mode_i,
   input logic        line_start_i,
   input logic        in_valid_i,
   input logic        in_ready_o,
   input logic        out_valid_o,
   input logic        out_ready_i,
   input logic        out_is_color_o,
   input logic [7:0]  out_index_o,
   input logic [23:0] out_color_o
);
   logic [2:0] cap_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cap_mode <= 3'd0;
      else if (in_valid_i && in_ready_o) cap_mode <= mode_i;
   end

   // R10: a stalled pixel is held until taken
   assert_hold_stalled_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o && !out_ready_i && !line_start_i |=>
         line_start_i || (out_valid_o && $stable(out_index_o) && $stable(out_color_o)
                          && $stable(out_is_color_o)));

   // R9: no new word while a stalled pixel is still pending
   assert_no_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o && !out_ready_i |-> !in_ready_o);

   // R11: a line start empties the holder
   assert_line_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
      line_start_i |=> !out_valid_o);

   // R2: index and color outputs are never both in use
   assert_kind_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o |-> (out_is_color_o ? (out_index_o == 8'd0) : (out_color_o == 24'd0)));

   // R6: 12-bit channels are zero-filled in their low nibbles
   assert_zero_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o && cap_mode == 3'd7 |->
         (out_color_o[3:0] == 4'h0 && out_color_o[11:8] == 4'h0 && out_color_o[19:16] == 4'h0));
endmodule

bind pix_unpack pu_checker u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .mode_i         (mode_i),
   .line_start_i   (line_start_i),
   .in_valid_i     (in_valid_i),
   .in_ready_o     (in_ready_o),
   .out_valid_o    (out_valid_o),
   .out_ready_i    (out_ready_i),
   .out_is_color_o (out_is_color_o),
   .out_index_o    (out_index_o),
   .out_color_o    (out_color_o)
);

// File: tb/test_pix_unpack.sv
module test_pix_unpack;
   localparam int WIDTH_W = 12;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [2:0]         mode_i = '0;
   logic               bgr_i = 1'b0, be_byte_i = 1'b0, be_pix_i = 1'b0;
   logic [1:0]         fmt_sel_i = '0;
   logic               line_start_i = 1'b0;
   logic               in_valid_i = 1'b0;
   logic               in_ready_o;
   logic [31:0]        in_data_i = '0;
   logic               out_valid_o;
   logic               out_ready_i = 1'b0;
   logic               out_is_color_o;
   logic [7:0]         out_index_o;
   logic [23:0]        out_color_o;
   logic [WIDTH_W-1:0] line_width_i = '0;
   logic [WIDTH_W+1:0] line_bytes_o;

   int checks = 0, fails = 0, cycles = 0;
   int bp_mode = 0;        // 0 always ready, 1 throttled, 2 held low
   logic [15:0] lfsr = 16'hACE1;
   logic [31:0] seed = 32'h1357_9BDF;
   logic [32:0] expq[$];
   string       tagq[$];
   bit          done = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   pix_unpack #(.WIDTH_W(WIDTH_W), .EXT_SEL_EN(1)) i_pix_unpack (.*);

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // independent reference for one pixel: {is_color, index, color}
   function automatic logic [32:0] model(input logic [31:0] w, input int mode, input bit bgr,
                                         input bit bb, input bit bpx, input int sel, input int k);
      int bpp, p;
      logic [31:0] raw;
      logic [7:0] r, g, b, t;
      bit sw;
      case (mode)
         0: bpp = 1; 1: bpp = 2; 2: bpp = 4; 3: bpp = 8; 5: bpp = 32;
         default: bpp = 16;
      endcase
      if (bb)                   p = 32 - (k + 1) * bpp;
      else if (bpx && bpp < 8)  p = ((k * bpp) / 8) * 8 + 8 - ((k % (8 / bpp)) + 1) * bpp;
      else                      p = k * bpp;
      raw = w >> p;
      if (bpp < 32) raw = raw & ((32'd1 << bpp) - 32'd1);
      if (mode <= 3) return {1'b0, raw[7:0], 24'd0};
      sw = bgr;
      if (mode == 5) begin
         r = raw[7:0]; g = raw[15:8]; b = raw[23:16];
      end else if (mode == 7) begin
         r = {raw[3:0], 4'h0}; g = {raw[7:4], 4'h0}; b = {raw[11:8], 4'h0};
      end else if (mode == 6 || (mode == 4 && sel != 1)) begin
         r = {raw[4:0], 3'b0}; g = {raw[10:5], 2'b0}; b = {raw[15:11], 3'b0};
         if (mode == 4 && sel == 3) sw = 1'b1;
      end else begin
         r = {raw[4:0], 3'b0}; g = {raw[9:5], 3'b0}; b = {raw[14:10], 3'b0};
      end
      if (sw) begin t = r; r = b; b = t; end
      return {1'b1, 8'd0, r, g, b};
   endfunction

   function automatic int per_word(input int mode);
      case (mode)
         0: return 32; 1: return 16; 2: return 8; 3: return 4; 5: return 1;
         default: return 2;
      endcase
   endfunction

   function automatic logic [31:0] next_word();
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      return seed;
   endfunction

   // downstream ready driver
   always @(posedge clk) begin
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (bp_mode)
         0: out_ready_i = 1'b1;
         1: out_ready_i = lfsr[0] | lfsr[3];
         default: out_ready_i = 1'b0;
      endcase
   end

   // monitor: scoreboard compare plus stall hold check (R10)
   bit prev_stall = 1'b0;
   logic [32:0] prev_out;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (prev_stall && !line_start_i)
            check(out_valid_o && {out_is_color_o, out_index_o, out_color_o} == prev_out,
                  "R10 stalled pixel held", {out_valid_o, out_is_color_o, out_index_o, out_color_o},
                  {1'b1, prev_out});
         if (out_valid_o && out_ready_i) begin
            if (expq.size() == 0) begin
               check(1'b0, "R1 unexpected pixel", {out_is_color_o, out_index_o, out_color_o}, 0);
            end else begin
               logic [32:0] e;
               string tg;
               e  = expq.pop_front();
               tg = tagq.pop_front();
               check({out_is_color_o, out_index_o, out_color_o} == e, tg,
                     {out_is_color_o, out_index_o, out_color_o}, e);
            end
         end
         prev_stall = out_valid_o && !out_ready_i && !line_start_i;
         prev_out   = {out_is_color_o, out_index_o, out_color_o};
      end
   end

   // driver: called at a posedge, returns at the accepting posedge
   task automatic send(input logic [31:0] w, input int mode, input bit bgr, input bit bb,
                       input bit bpx, input int sel, output int waits);
      bit acc;
      string tg;
      #1;
      in_data_i = w; mode_i = 3'(mode); bgr_i = bgr; be_byte_i = bb; be_pix_i = bpx;
      fmt_sel_i = 2'(sel); in_valid_i = 1'b1;
      waits = 0;
      do begin
         @(negedge clk);
         acc = in_ready_o;
         waits++;
         @(posedge clk);
      end while (!acc);
      if (bb)                 tg = "R1/R4 order";
      else if (bpx)           tg = "R1/R5 order";
      else if (mode == 4)     tg = "R8 format select";
      else if (mode > 3 && bgr) tg = "R7 channel swap";
      else if (mode > 3)      tg = "R6 direct color";
      else                    tg = "R2/R3 index";
      for (int k = 0; k < per_word(mode); k++) begin
         expq.push_back(model(w, mode, bgr, bb, bpx, sel, k));
         tagq.push_back(tg);
      end
   endtask

   task automatic idle_in();
      #1 in_valid_i = 1'b0;
      @(posedge clk);
   endtask

   task automatic drain();
      while (expq.size() != 0) @(posedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired, actual=%0d cycles expected<150000", cycles);
            finish_run();
         end
      end
   end

   initial begin
      int w8;
      // R13: reset state
      repeat (3) @(negedge clk);
      check(!out_valid_o, "R13 out_valid in reset", out_valid_o, 0);
      check(in_ready_o, "R13 in_ready in reset", in_ready_o, 1);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      check(!out_valid_o && in_ready_o, "R13 after reset", {out_valid_o, in_ready_o}, 2'b01);

      // R12: bytes per line for every mode
      line_width_i = 12'd640;
      for (int m = 0; m < 8; m++) begin
         int e;
         case (m)
            0: e = 80; 1: e = 160; 2: e = 320; 3: e = 640; 5: e = 2560;
            default: e = 1280;
         endcase
         @(posedge clk); #1 mode_i = 3'(m);
         @(negedge clk);
         check(int'(line_bytes_o) == e, "R12 line bytes", line_bytes_o, e);
      end
      @(posedge clk); #1 line_width_i = 12'd4095; mode_i = 3'd5;
      @(negedge clk);
      check(int'(line_bytes_o) == 16380, "R12 line bytes max width", line_bytes_o, 16380);

      // R1..R7: every mode, order and swap, with throttled downstream
      bp_mode = 1;
      @(posedge clk);
      for (int ord = 0; ord < 4; ord++)
         for (int sw = 0; sw < 2; sw++)
            for (int m = 0; m < 8; m++)
               if (m != 4) send(next_word(), m, sw[0], ord[1], ord[0], 0, w8);
      // R8: mode 4 with each format select
      for (int s = 0; s < 4; s++)
         for (int sw = 0; sw < 2; sw++)
            for (int rep = 0; rep < 2; rep++)
               send(next_word(), 4, sw[0], 1'b0, 1'b0, s, w8);
      // R6: top byte ignored at 32 bpp
      send(32'hFF12_3456, 5, 1'b0, 1'b0, 1'b0, 0, w8);
      idle_in();
      drain();

      // R9: back-to-back 32 bpp words with no bubble
      bp_mode = 0;
      @(posedge clk);
      send(next_word(), 5, 1'b0, 1'b0, 1'b0, 0, w8);
      for (int i = 0; i < 4; i++) begin
         send(next_word(), 5, 1'b1, 1'b0, 1'b0, 0, w8);
         check(w8 == 1, "R9 word accepted with last pixel", w8, 1);
      end
      idle_in();
      drain();

      // R9 / R11: held word blocks input, line start discards it
      bp_mode = 2;
      @(posedge clk);
      send(32'hDEAD_BEEF, 0, 1'b0, 1'b0, 1'b0, 0, w8);
      #1 in_valid_i = 1'b1; in_data_i = 32'h0403_0201; mode_i = 3'd3;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check(!in_ready_o && out_valid_o, "R9 input held off", {in_ready_o, out_valid_o}, 2'b01);
      end
      @(posedge clk); #1 line_start_i = 1'b1;
      @(negedge clk);
      check(!in_ready_o && !out_valid_o, "R11 handshakes low at line start",
            {in_ready_o, out_valid_o}, 2'b00);
      @(posedge clk); #1 line_start_i = 1'b0; in_valid_i = 1'b0;
      expq.delete(); tagq.delete();
      @(negedge clk);
      check(!out_valid_o, "R11 word discarded", out_valid_o, 0);
      bp_mode = 0;
      @(posedge clk);
      send(32'h0403_0201, 3, 1'b0, 1'b0, 1'b0, 0, w8);
      for (int i = 0; i < 4; i++) tagq[i] = "R11 restart at pixel 0";
      idle_in();
      drain();
      repeat (3) @(posedge clk);
      check(expq.size() == 0 && !out_valid_o, "R1 all pixels delivered", expq.size(), 0);
      finish_run();
   end
endmodule